// File: doc/BRIEF.md
# Serial Port Buffer and Status Flag Unit

This block is the register layer of an asynchronous serial port. It sits between a CPU register bus and the transmit and receive shift engines, which already exist. On the transmit side it holds one byte for the CPU. When the transmit engine reports idle and a byte is waiting, it hands that byte over. On the receive side it accepts each finished character, together with the character's framing and parity check results. It then decides whether the character goes into the receive data register and updates five status flags.

Any combination of overrun, framing and parity errors can arise from a single character, and all of them are flagged in the same cycle. An overrun discards the incoming character and leaves the receive-full flag as it was. A framing or parity error alone still lets the character through. The CPU clears a flag by first reading it as 1 in the status register and then writing 0 to that bit.

Top module: `sio_buf_flags`

## Requirements
- R1: After reset the status register reads 0x80: transmit-empty is 1 and every other flag is 0. The receive data register reads 0 and `tx_load` is low.
- R2: A write to address 0 stores the byte in the transmit holding register and clears transmit-empty. The write is taken even when transmit-empty is 0, and the earlier byte is then lost. A read of address 0 returns the held byte.
- R3: `tx_load` is high in exactly the cycles where `tx_idle` is 1 and transmit-empty is 0. While it is high, `tx_byte` carries the held byte. Transmit-empty reads 1 from the following cycle, unless address 0 is written in the same cycle as the handover; in that case the new byte is kept and transmit-empty stays 0.
- R4: A character whose `rx_done` arrives while receive-full is 0 is copied into the receive data register, which is read at address 1, and receive-full is set.
- R5: A character that has only a framing error, only a parity error, or both is still copied in. Its error inputs set the framing flag (status bit 4) and the parity flag (status bit 3).
- R6: A character that arrives while receive-full is 1 sets the overrun flag (status bit 5). The character is dropped: the receive data register keeps its old value and receive-full keeps its value.
- R7: When one character carries overrun, framing and parity errors together, all three flags are set in the same cycle.
- R8: Writing the status register (address 2) clears each flag whose written bit is 0, but only if that flag was read as 1 in an earlier status read. A written 1 changes nothing, and a 0 written to a flag that has not been read as 1 changes nothing.
- R9: Reading the receive data register leaves receive-full unchanged.
- R10: The status byte is laid out as bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing, bit 3 parity, with bits 2..0 reading 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register select: 0 transmit, 1 receive, 2 status |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (arms status flags for clearing) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for the selected address (combinational) |
| tx_idle | input | 1 | Transmit engine can accept a byte |
| tx_load | output | 1 | Handover strobe to the transmit engine |
| tx_byte | output | DATA_W | Byte handed to the transmit engine |
| rx_done | input | 1 | Receive engine finished a character |
| rx_char | input | DATA_W | Finished character |
| rx_frame_err | input | 1 | Stop bit of that character was bad |
| rx_parity_err | input | 1 | Parity of that character was bad |

## Verification
A fault in the transmit-empty flag shows at the status port one cycle after a write or handover. It also shows at once on `tx_load`, which either hands over a byte twice or stalls. A wrong overrun decision is visible in the next read of address 1, which holds a character that should have been dropped, and in bit 6 or bit 5 of the status byte. A fault in the arm-before-clear logic shows up only after a status write that follows a read, so the bench checks status writes made both with and without a prior read.

// File: rtl/sio_buf_flags.sv
module sio_buf_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              tx_idle,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err
);
  localparam int NFLAG = 5;
  localparam int FLAG_LSB = 8 - NFLAG;

  logic [DATA_W-1:0] tdr_q, rdr_q;
  logic [NFLAG-1:0]  flg_q, flg_d, arm_q, clr, set;
  logic              wr_tdr, wr_st, rd_st;

  wire tdre = flg_q[4];
  wire rdrf = flg_q[3];
  wire oer  = flg_q[2];
  wire fer  = flg_q[1];
  wire per  = flg_q[0];

  assign wr_tdr = cpu_wr && cpu_addr == 2'd0;
  assign wr_st  = cpu_wr && cpu_addr == 2'd2;
  assign rd_st  = cpu_rd && cpu_addr == 2'd2;

  assign tx_load = tx_idle && !tdre;
  assign tx_byte = tdr_q;

  assign clr = {NFLAG{wr_st}} & arm_q & ~cpu_wdata[7:FLAG_LSB];
  assign set = {tx_load && !wr_tdr,
                rx_done && !rdrf,
                rx_done && rdrf,
                rx_done && rx_frame_err,
                rx_done && rx_parity_err};
  assign flg_d = (flg_q & ~clr & ~{wr_tdr, {NFLAG-1{1'b0}}}) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= {1'b1, {NFLAG-1{1'b0}}};
      arm_q <= '0;
      tdr_q <= '0;
      rdr_q <= '0;
    end else begin
      flg_q <= flg_d;
      arm_q <= (arm_q | (rd_st ? flg_q : '0)) & flg_d;
      if (wr_tdr) tdr_q <= cpu_wdata;
      if (rx_done && !rdrf) rdr_q <= rx_char;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      2'd0: cpu_rdata = tdr_q;
      2'd1: cpu_rdata = rdr_q;
      2'd2: cpu_rdata[7:0] = {flg_q, {FLAG_LSB{1'b0}}};
      default: cpu_rdata = '0;
    endcase
  end

  p_tdr_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tdr |=> !tdre && tdr_q == $past(cpu_wdata));

  p_handover_sets_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !wr_tdr && !wr_st |=> tdre);

  p_copy_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rdrf |=> rdrf && rdr_q == $past(rx_char));

  p_errors_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (fer || !$past(rx_frame_err)) && (per || !$past(rx_parity_err))
                && (oer || !$past(rdrf)));

  p_overrun_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rdrf && !wr_st |=> rdrf && oer && $stable(rdr_q));

  p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && cpu_wdata[7:FLAG_LSB] == {NFLAG{1'b1}} && !wr_tdr |=> $countones(flg_q) >= $countones($past(flg_q)) - 1 && (rdrf || !$past(rdrf)));

  p_read_keeps_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == 2'd1 && rdrf |=> rdrf);

  p_status_idle_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == 2'd2 |-> cpu_rdata[FLAG_LSB-1:0] == '0);
endmodule

// File: tb/sio_buf_flags_test.sv
module sio_buf_flags_test;
  logic       clk = 0, rst_n = 0;
  logic [1:0] cpu_addr = 0;
  logic       cpu_wr = 0, cpu_rd = 0, tx_idle = 0, rx_done = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic [7:0] cpu_wdata = 0, rx_char = 0;
  logic [7:0] cpu_rdata, tx_byte;
  logic       tx_load;
  int checks = 0, fails = 0;
  bit  done = 0;

  sio_buf_flags #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_idle(tx_idle), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_done(rx_done), .rx_char(rx_char),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err));

  always #5 clk = ~clk;

  // op[31:28] 0 write, 1 read+check, 2 receive, 3 idle+check load
  // addr[27:26] fe[25] pe[24] data[23:16] expected[15:8] requirement[7:0]
  localparam int NV = 32;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1,2'd2,2'b00,8'h00,8'h80,8'd1},   // R1 R10 reset status
    {4'd1,2'd1,2'b00,8'h00,8'h00,8'd1},   // R1 receive data cleared
    {4'd3,2'd0,2'b00,8'h00,8'h00,8'd3},   // R3 no load while empty
    {4'd0,2'd0,2'b00,8'hA5,8'h00,8'd2},   // R2 first write
    {4'd1,2'd2,2'b00,8'h00,8'h00,8'd2},   // R2 empty cleared
    {4'd0,2'd0,2'b00,8'h3C,8'h00,8'd2},   // R2 overwrite
    {4'd1,2'd0,2'b00,8'h00,8'h3C,8'd2},   // R2 latest byte kept
    {4'd3,2'd0,2'b00,8'h3C,8'h01,8'd3},   // R3 handover
    {4'd1,2'd2,2'b00,8'h00,8'h80,8'd3},   // R3 empty again
    {4'd2,2'd0,2'b00,8'h55,8'h00,8'd4},   // R4 clean char
    {4'd1,2'd2,2'b00,8'h00,8'hC0,8'd4},
    {4'd1,2'd1,2'b00,8'h00,8'h55,8'd4},   // R4 R9
    {4'd1,2'd2,2'b00,8'h00,8'hC0,8'd9},   // R9 full still set
    {4'd2,2'd0,2'b11,8'hAA,8'h00,8'd7},   // R6 R7 overrun+frame+parity
    {4'd1,2'd2,2'b00,8'h00,8'hF8,8'd7},
    {4'd1,2'd1,2'b00,8'h00,8'h55,8'd6},   // R6 dropped
    {4'd0,2'd2,2'b00,8'hFF,8'h00,8'd8},   // R8 write ones
    {4'd1,2'd2,2'b00,8'h00,8'hF8,8'd8},
    {4'd0,2'd2,2'b00,8'h87,8'h00,8'd8},   // R8 clear four
    {4'd1,2'd2,2'b00,8'h00,8'h80,8'd8},
    {4'd2,2'd0,2'b10,8'h66,8'h00,8'd5},   // R5 frame only
    {4'd0,2'd2,2'b00,8'h80,8'h00,8'd8},   // R8 zero without read
    {4'd1,2'd2,2'b00,8'h00,8'hD0,8'd8},
    {4'd1,2'd1,2'b00,8'h00,8'h66,8'd5},
    {4'd0,2'd2,2'b00,8'h80,8'h00,8'd8},
    {4'd1,2'd2,2'b00,8'h00,8'h80,8'd8},
    {4'd2,2'd0,2'b01,8'h77,8'h00,8'd5},   // R5 parity only
    {4'd1,2'd2,2'b00,8'h00,8'hC8,8'd5},
    {4'd1,2'd1,2'b00,8'h00,8'h77,8'd5},
    {4'd0,2'd2,2'b00,8'h00,8'h00,8'd8},   // R8 clears empty too
    {4'd1,2'd2,2'b00,8'h00,8'h00,8'd8},
    {4'd3,2'd0,2'b00,8'h3C,8'h01,8'd3}    // R3 handover of held byte
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    cpu_wr = 0; cpu_rd = 0; tx_idle = 0; rx_done = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input int req, input string what);
    @(negedge clk); idle_bus(); cpu_addr = a; cpu_rd = 1;
    #1 check(cpu_rdata, exp, req, what);
    @(negedge clk); idle_bus();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      @(negedge clk); idle_bus();
      cpu_addr = v[27:26];
      case (v[31:28])
        4'd0: begin cpu_wr = 1; cpu_wdata = v[23:16]; end
        4'd1: begin cpu_rd = 1; #1 check(cpu_rdata, v[15:8], int'(v[7:0]), "vector read"); end
        4'd2: begin rx_done = 1; rx_char = v[23:16]; rx_frame_err = v[25]; rx_parity_err = v[24]; end
        default: begin
          tx_idle = 1;
          #1 check({7'd0, tx_load}, v[15:8], int'(v[7:0]), "load strobe");
          if (v[8]) check(tx_byte, v[23:16], int'(v[7:0]), "handed byte");
        end
      endcase
      @(negedge clk); idle_bus();
    end

    // R3 write in the same cycle as handover: old byte leaves, new byte stays, empty stays 0
    @(negedge clk); idle_bus(); cpu_addr = 0; cpu_wr = 1; cpu_wdata = 8'h22;
    @(negedge clk); idle_bus(); cpu_addr = 0; cpu_wr = 1; cpu_wdata = 8'h11; tx_idle = 1;
    #1 check({7'd0, tx_load}, 8'h01, 3, "load with write");
    check(tx_byte, 8'h22, 3, "old byte handed");
    @(negedge clk); idle_bus();
    rd_check(2'd2, 8'h00, 3, "empty stays 0");
    rd_check(2'd0, 8'h11, 2, "new byte kept");

    // R10 unused address
    rd_check(2'd3, 8'h00, 10, "address 3");

    // R1 reset in mid-run
    @(negedge clk); idle_bus(); rx_done = 1; rx_char = 8'h9E;
    @(negedge clk); idle_bus(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_check(2'd2, 8'h80, 1, "status after reset");
    rd_check(2'd1, 8'h00, 1, "receive data after reset");
    @(negedge clk); idle_bus(); tx_idle = 1;
    #1 check({7'd0, tx_load}, 8'h00, 1, "no load after reset");
    @(negedge clk); idle_bus();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule